// File: doc/BRIEF.md
# Five-Stage Pipelined Integer Datapath

This block is an in-order load/store processor core. Every instruction moves through five stages: fetch, decode, execute, memory access and write-back. Pipeline registers sit between the stages, and at most one instruction starts per cycle. Instruction memory and data memory are reached through two separate ports, so a load or store never competes with fetch. The register file has two read ports and one write port. It is write-through: a value retiring in write-back is seen by an instruction decoding in the same cycle.

The core does not forward operands and does not stall. Software must place at least two unrelated instructions or no-ops between a producer and a consumer. With that spacing the consumer decodes in the cycle the producer writes back. A branch compares two registers in execute and takes effect in the memory stage. When it is taken, the PC is redirected and the three instructions behind the branch are turned into bubbles. The memories are outside the block: instruction data and load data are read combinationally in the cycle their address is presented, and a store is written at the end of its memory-stage cycle.

Top module: `pipe5_core`

## Requirements
- R1: While `rst` is high, `imemAddr` is 0 and neither `dmemWe` nor `dmemRe` is asserted. Reset is synchronous and fills every stage with a no-op.
- R2: With no taken branch, `imemAddr` (the PC) rises by 4 each cycle. The first cycle after reset release fetches address 4.
- R3: Instruction encoding:
  - opcode: bits [31:26]
  - rd: bits [25:21]
  - rs1: bits [20:16]
  - rs2: bits [15:11]
  - funct: bits [2:0]
  - immediate: bits [15:0], sign-extended
  - opcodes: 0 no-op, 1 register-register, 2 add-immediate, 3 load, 4 store, 5 branch-if-equal
- R4: A register-register instruction writes rs1 OP rs2 to rd. The funct values are:
  - 0 add
  - 1 subtract
  - 2 and
  - 3 or
  - 4 xor
  - 5 signed set-less-than
  - 6 shift left by the low 5 bits of rs2
  - 7 logical shift right by the low 5 bits of rs2
- R5: Add-immediate writes rs1 + sign-extended immediate to rd.
- R6: A load writes data memory word [rs1 + immediate] to rd. In its memory-stage cycle it asserts `dmemRe` with that address.
- R7: A store drives `dmemWe` with address rs1 + immediate. The data is the register named by the rd field.
- R8: A register written back in a given cycle is read with its new value by the instruction decoding in that same cycle, which is the third instruction after the producer.
- R9: Register 0 always reads as zero. Writes to it, including one retiring in the same cycle as the read, are ignored.
- R10: Branch-if-equal compares rs1 with the register named by the rd field. When they are equal, fetch continues at branch address + 4 + immediate, and the three instructions after the branch write no register and no memory. When they differ, execution falls through.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| imemAddr | output | XLEN | Byte address of the instruction being fetched (PC) |
| imemData | input | 32 | Instruction word at `imemAddr`, same cycle |
| dmemAddr | output | XLEN | Data memory byte address (memory stage) |
| dmemWData | output | XLEN | Store data |
| dmemWe | output | 1 | Store strobe, memory written at the clock edge |
| dmemRe | output | 1 | Load strobe |
| dmemRData | input | XLEN | Data memory word at `dmemAddr`, same cycle |

## Verification
Straight-line programs of register-register operations use random operands from sign-extended 16-bit immediates. Together they cover all eight funct codes, which separates mix-ups in operation decode, signedness and shift amount. Directed programs place a consumer exactly three slots after its producer; a consumer that reads stale data shows that write-through is missing. A write to register 0 retires in the same cycle it is read, which shows whether the write-through path wrongly applies to register 0. Load and store programs use zero and negative offsets, and a load follows a store to the same word. A taken branch is followed by three stores that must not happen and a not-taken branch by three that must, which separates a wrong flush depth from a wrong target or a wrong compare.

// File: rtl/pipe5_pkg.sv
package pipe5_pkg;
  localparam int INSTR_W  = 32;
  localparam int REG_AW   = 5;
  localparam int NUM_REGS = 1 << REG_AW;

  typedef enum logic [5:0] {
    OP_NOP   = 6'd0,
    OP_REG   = 6'd1,
    OP_ADDI  = 6'd2,
    OP_LOAD  = 6'd3,
    OP_STORE = 6'd4,
    OP_BEQ   = 6'd5
  } opcodeT;

  typedef enum logic [2:0] {
    ALU_ADD = 3'd0,
    ALU_SUB = 3'd1,
    ALU_AND = 3'd2,
    ALU_OR  = 3'd3,
    ALU_XOR = 3'd4,
    ALU_SLT = 3'd5,
    ALU_SLL = 3'd6,
    ALU_SRL = 3'd7
  } aluOpT;

  // strobes consumed after execute
  typedef struct packed {
    logic regWrite;
    logic memRead;
    logic memWrite;
    logic branch;
    logic loadToReg;
  } lateCtrlT;

  // full decode result handed from control to datapath
  typedef struct packed {
    lateCtrlT late;
    logic     immOperand;
    logic     rdIsSource;
    aluOpT    aluOp;
  } ctrlT;
endpackage

// File: rtl/pipe5_ctrl.sv
module pipe5_ctrl
  import pipe5_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [2:0] funct,
  input  logic       memBranch,
  input  logic       memEqual,
  output ctrlT       decCtrl,
  output logic       redirect
);
  always_comb begin
    decCtrl = ctrlT'(0);
    case (opcodeT'(opcode))
      OP_REG: begin
        decCtrl.late.regWrite = 1'b1;
        decCtrl.aluOp         = aluOpT'(funct);
      end
      OP_ADDI: begin
        decCtrl.late.regWrite = 1'b1;
        decCtrl.immOperand    = 1'b1;
      end
      OP_LOAD: begin
        decCtrl.late.regWrite  = 1'b1;
        decCtrl.late.memRead   = 1'b1;
        decCtrl.late.loadToReg = 1'b1;
        decCtrl.immOperand     = 1'b1;
      end
      OP_STORE: begin
        decCtrl.late.memWrite = 1'b1;
        decCtrl.immOperand    = 1'b1;
        decCtrl.rdIsSource    = 1'b1;
      end
      OP_BEQ: begin
        decCtrl.late.branch = 1'b1;
        decCtrl.rdIsSource  = 1'b1;
        decCtrl.aluOp       = ALU_SUB;
      end
      default: decCtrl = ctrlT'(0);
    endcase
  end

  // branch outcome is known once the branch sits in the memory stage
  assign redirect = memBranch & memEqual;
endmodule

// File: rtl/pipe5_regfile.sv
module pipe5_regfile
  import pipe5_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [1:0][REG_AW-1:0]      rdAddr,
  output logic [1:0][XLEN-1:0]        rdData,
  input  logic                        wrEn,
  input  logic [REG_AW-1:0]           wrAddr,
  input  logic [XLEN-1:0]             wrData
);
  localparam int NUM_RD = 2;

  logic [XLEN-1:0] regs [NUM_REGS];
  logic            wrLive;

  assign wrLive = wrEn && (wrAddr != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= '0;
    end else if (wrLive) begin
      regs[wrAddr] <= wrData;
    end
  end

  // write lands in the first half of the cycle: same-cycle readers see it
  for (genvar p = 0; p < NUM_RD; p++) begin : gRead
    always_comb begin
      if (rdAddr[p] == '0)                  rdData[p] = '0;
      else if (wrLive && wrAddr == rdAddr[p]) rdData[p] = wrData;
      else                                  rdData[p] = regs[rdAddr[p]];
    end

    a_r9_zero_reads: assert property (@(posedge clk) disable iff (rst)
      (rdAddr[p] == '0) |-> (rdData[p] == '0));
  end

  a_r8_write_lands: assert property (@(posedge clk) disable iff (rst)
    (wrEn && wrAddr != '0) |=> (regs[$past(wrAddr)] == $past(wrData)));
endmodule

// File: rtl/pipe5_datapath.sv
module pipe5_datapath
  import pipe5_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int PC_STEP = 4
) (
  input  logic               clk,
  input  logic               rst,
  output logic [XLEN-1:0]    imemAddr,
  input  logic [INSTR_W-1:0] imemData,
  output logic [XLEN-1:0]    dmemAddr,
  output logic [XLEN-1:0]    dmemWData,
  output logic               dmemWe,
  output logic               dmemRe,
  input  logic [XLEN-1:0]    dmemRData,
  output logic [5:0]         decOpcode,
  output logic [2:0]         decFunct,
  input  ctrlT               decCtrl,
  input  logic               redirect,
  output logic               memBranch,
  output logic               memEqual
);
  localparam int SHW = $clog2(XLEN);

  typedef struct packed {
    logic               valid;
    logic [INSTR_W-1:0] instr;
    logic [XLEN-1:0]    npc;
  } ifIdT;

  typedef struct packed {
    logic              valid;
    lateCtrlT          late;
    logic              immOperand;
    aluOpT             aluOp;
    logic [XLEN-1:0]   opA;
    logic [XLEN-1:0]   opB;
    logic [XLEN-1:0]   imm;
    logic [XLEN-1:0]   npc;
    logic [REG_AW-1:0] rd;
  } idExT;

  typedef struct packed {
    logic              valid;
    lateCtrlT          late;
    logic [XLEN-1:0]   result;
    logic [XLEN-1:0]   storeData;
    logic [XLEN-1:0]   target;
    logic              equal;
    logic [REG_AW-1:0] rd;
  } exMemT;

  typedef struct packed {
    logic              valid;
    logic              regWrite;
    logic              loadToReg;
    logic [XLEN-1:0]   result;
    logic [XLEN-1:0]   loadData;
    logic [REG_AW-1:0] rd;
  } memWbT;

  ifIdT  ifId;
  idExT  idEx;
  exMemT exMem;
  memWbT memWb;

  // ---------------- fetch ----------------
  logic [XLEN-1:0] pc, seqPc, pcNext;

  assign seqPc    = pc + XLEN'(PC_STEP);
  assign pcNext   = redirect ? exMem.target : seqPc;
  assign imemAddr = pc;

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= pcNext;
  end

  always_ff @(posedge clk) begin
    if (rst || redirect) begin
      ifId <= '0;
    end else begin
      ifId.valid <= 1'b1;
      ifId.instr <= imemData;
      ifId.npc   <= seqPc;
    end
  end

  a_r2_seq_fetch: assert property (@(posedge clk) disable iff (rst)
    !redirect |=> (pc == $past(pc) + XLEN'(PC_STEP)));

  // ---------------- decode ----------------
  logic [INSTR_W-1:0]       decInstr;
  logic [1:0][REG_AW-1:0]   rfRdAddr;
  logic [1:0][XLEN-1:0]     rfRdData;
  logic [XLEN-1:0]          immExt;
  logic [XLEN-1:0]          wbData;
  logic                     wbEn;

  assign decInstr    = ifId.valid ? ifId.instr : '0;
  assign decOpcode   = decInstr[31:26];
  assign decFunct    = decInstr[2:0];
  assign rfRdAddr[0] = decInstr[20:16];
  assign rfRdAddr[1] = decCtrl.rdIsSource ? decInstr[25:21] : decInstr[15:11];
  assign immExt      = {{(XLEN-16){decInstr[15]}}, decInstr[15:0]};

  pipe5_regfile #(.XLEN(XLEN)) regfile_i (
    .clk    (clk),
    .rst    (rst),
    .rdAddr (rfRdAddr),
    .rdData (rfRdData),
    .wrEn   (wbEn),
    .wrAddr (memWb.rd),
    .wrData (wbData)
  );

  always_ff @(posedge clk) begin
    if (rst || redirect) begin
      idEx <= '0;
    end else begin
      idEx.valid      <= ifId.valid;
      idEx.late       <= decCtrl.late;
      idEx.immOperand <= decCtrl.immOperand;
      idEx.aluOp      <= decCtrl.aluOp;
      idEx.opA        <= rfRdData[0];
      idEx.opB        <= rfRdData[1];
      idEx.imm        <= immExt;
      idEx.npc        <= ifId.npc;
      idEx.rd         <= decInstr[25:21];
    end
  end

  // ---------------- execute ----------------
  logic [XLEN-1:0] aluA, aluB, aluOut;

  assign aluA = idEx.opA;
  assign aluB = idEx.immOperand ? idEx.imm : idEx.opB;

  always_comb begin
    case (idEx.aluOp)
      ALU_ADD: aluOut = aluA + aluB;
      ALU_SUB: aluOut = aluA - aluB;
      ALU_AND: aluOut = aluA & aluB;
      ALU_OR:  aluOut = aluA | aluB;
      ALU_XOR: aluOut = aluA ^ aluB;
      ALU_SLT: aluOut = {{(XLEN-1){1'b0}}, ($signed(aluA) < $signed(aluB))};
      ALU_SLL: aluOut = aluA << aluB[SHW-1:0];
      ALU_SRL: aluOut = aluA >> aluB[SHW-1:0];
      default: aluOut = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || redirect) begin
      exMem <= '0;
    end else begin
      exMem.valid     <= idEx.valid;
      exMem.late      <= idEx.late;
      exMem.result    <= aluOut;
      exMem.storeData <= idEx.opB;
      exMem.target    <= idEx.npc + idEx.imm;
      exMem.equal     <= (idEx.opA == idEx.opB);
      exMem.rd        <= idEx.rd;
    end
  end

  // ---------------- memory ----------------
  assign dmemAddr  = exMem.result;
  assign dmemWData = exMem.storeData;
  assign dmemWe    = exMem.valid & exMem.late.memWrite;
  assign dmemRe    = exMem.valid & exMem.late.memRead;
  assign memBranch = exMem.valid & exMem.late.branch;
  assign memEqual  = exMem.equal;

  always_ff @(posedge clk) begin
    if (rst) begin
      memWb <= '0;
    end else begin
      memWb.valid     <= exMem.valid;
      memWb.regWrite  <= exMem.late.regWrite;
      memWb.loadToReg <= exMem.late.loadToReg;
      memWb.result    <= exMem.result;
      memWb.loadData  <= dmemRData;
      memWb.rd        <= exMem.rd;
    end
  end

  a_r6_r7_one_access: assert property (@(posedge clk) disable iff (rst)
    !(dmemWe && dmemRe));

  a_r10_flush_bubbles: assert property (@(posedge clk) disable iff (rst)
    redirect |=> (!ifId.valid && !idEx.valid && !exMem.valid));

  a_r10_redirect_target: assert property (@(posedge clk) disable iff (rst)
    redirect |=> (pc == $past(exMem.target)));

  // ---------------- write-back ----------------
  assign wbEn   = memWb.valid & memWb.regWrite;
  assign wbData = memWb.loadToReg ? memWb.loadData : memWb.result;
endmodule

// File: rtl/pipe5_core.sv
module pipe5_core
  import pipe5_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic               clk,
  input  logic               rst,
  output logic [XLEN-1:0]    imemAddr,
  input  logic [INSTR_W-1:0] imemData,
  output logic [XLEN-1:0]    dmemAddr,
  output logic [XLEN-1:0]    dmemWData,
  output logic               dmemWe,
  output logic               dmemRe,
  input  logic [XLEN-1:0]    dmemRData
);
  logic [5:0] decOpcode;
  logic [2:0] decFunct;
  ctrlT       decCtrl;
  logic       redirect;
  logic       memBranch;
  logic       memEqual;

  pipe5_ctrl ctrl_i (
    .opcode    (decOpcode),
    .funct     (decFunct),
    .memBranch (memBranch),
    .memEqual  (memEqual),
    .decCtrl   (decCtrl),
    .redirect  (redirect)
  );

  pipe5_datapath #(.XLEN(XLEN)) datapath_i (
    .clk       (clk),
    .rst       (rst),
    .imemAddr  (imemAddr),
    .imemData  (imemData),
    .dmemAddr  (dmemAddr),
    .dmemWData (dmemWData),
    .dmemWe    (dmemWe),
    .dmemRe    (dmemRe),
    .dmemRData (dmemRData),
    .decOpcode (decOpcode),
    .decFunct  (decFunct),
    .decCtrl   (decCtrl),
    .redirect  (redirect),
    .memBranch (memBranch),
    .memEqual  (memEqual)
  );

  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!dmemWe && !dmemRe));
endmodule

// File: tb/pipe5_core_tb_top.sv
module pipe5_core_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MEM_WORDS  = 64;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] imemAddr, imemData, dmemAddr, dmemWData, dmemRData;
  logic        dmemWe, dmemRe;

  logic [31:0] imem [MEM_WORDS];
  logic [31:0] dmem [MEM_WORDS];

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int storeCount = 0;
  int slot = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pipe5_core dut_i (
    .clk       (clk),
    .rst       (rst),
    .imemAddr  (imemAddr),
    .imemData  (imemData),
    .dmemAddr  (dmemAddr),
    .dmemWData (dmemWData),
    .dmemWe    (dmemWe),
    .dmemRe    (dmemRe),
    .dmemRData (dmemRData)
  );

  assign imemData  = imem[imemAddr[7:2]];
  assign dmemRData = dmem[dmemAddr[7:2]];

  always @(posedge clk) begin
    if (dmemWe) begin
      dmem[dmemAddr[7:2]] <= dmemWData;
      storeCount <= storeCount + 1;
    end
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WATCHDOG) begin
      checks = checks + 1;
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles expected at most %0d", cycles, WATCHDOG);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] encR(input int funct, input int rd, input int rs1, input int rs2);
    return {6'd1, 5'(rd), 5'(rs1), 5'(rs2), 8'd0, 3'(funct)};
  endfunction

  function automatic logic [31:0] encI(input int op, input int rd, input int rs1, input int imm);
    return {6'(op), 5'(rd), 5'(rs1), 16'(imm)};
  endfunction

  function automatic logic [31:0] aluModel(input int funct, input logic [31:0] a, input logic [31:0] b);
    case (funct)
      0: return a + b;
      1: return a - b;
      2: return a & b;
      3: return a | b;
      4: return a ^ b;
      5: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      6: return a << b[4:0];
      default: return a >> b[4:0];
    endcase
  endfunction

  task automatic emit(input logic [31:0] instr);
    imem[slot] = instr;
    slot = slot + 1;
  endtask

  task automatic holdAndClear();
    @(negedge clk);
    rst = 1'b1;
    for (int i = 0; i < MEM_WORDS; i++) begin
      imem[i] = 32'd0;
      dmem[i] = 32'd0;
    end
    slot = 0;
  endtask

  task automatic releaseAndRun(input int n);
    repeat (2) @(negedge clk);
    storeCount = 0;
    rst = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < MEM_WORDS; i++) begin
      imem[i] = 32'd0;
      dmem[i] = 32'd0;
    end

    // R1 reset state, R2 sequential fetch
    repeat (3) @(negedge clk);
    check("R1", "imemAddr in reset", imemAddr, 32'd0);
    check("R1", "dmemWe in reset", {31'd0, dmemWe}, 32'd0);
    check("R1", "dmemRe in reset", {31'd0, dmemRe}, 32'd0);
    rst = 1'b0;
    for (int k = 1; k <= 4; k++) begin
      @(negedge clk);
      check("R2", "pc step", imemAddr, 32'(4 * k));
    end

    // R4 R3 random register-register programs
    for (int p = 0; p < 3; p++) begin
      logic [31:0] vals [5];
      logic [31:0] expv [6];
      holdAndClear();
      for (int r = 1; r <= 4; r++) begin
        int imm = int'($urandom & 32'hFFFF);
        vals[r] = {{16{imm[15]}}, imm[15:0]};
        emit(encI(2, r, 0, imm));
      end
      emit(32'd0);
      emit(32'd0);
      for (int k = 0; k < 6; k++) begin
        int f  = (p * 6 + k) % 8;
        int ra = int'($urandom % 4) + 1;
        int rb = int'($urandom % 4) + 1;
        expv[k] = aluModel(f, vals[ra], vals[rb]);
        emit(encR(f, 5, ra, rb));
        emit(32'd0);
        emit(32'd0);
        emit(encI(4, 5, 0, 4 * k));
      end
      emit(encI(5, 0, 0, -4));
      releaseAndRun(80);
      for (int k = 0; k < 6; k++)
        check("R4", $sformatf("prog %0d op %0d funct %0d", p, k, (p * 6 + k) % 8), dmem[k], expv[k]);
    end

    // R8 same-cycle write/read, R9 register zero, R5 negative immediate
    holdAndClear();
    emit(encI(2, 1, 0, 5));        // 0
    emit(32'd0);                   // 1
    emit(32'd0);                   // 2
    emit(encR(0, 2, 1, 0));        // 3: reads r1 as it retires
    emit(encI(2, 0, 0, 7));        // 4: write to r0
    emit(encI(2, 3, 0, -3));       // 5
    emit(32'd0);                   // 6
    emit(encI(4, 0, 0, 4));        // 7: reads r0 as the r0 write retires
    emit(encI(4, 2, 0, 0));        // 8
    emit(encI(4, 3, 0, 8));        // 9
    emit(encI(5, 0, 0, -4));
    releaseAndRun(40);
    check("R8", "same-cycle read of r1", dmem[0], 32'd5);
    check("R9", "r0 after write", dmem[1], 32'd0);
    check("R5", "negative immediate", dmem[2], 32'hFFFF_FFFD);

    // R6 loads, R7 stores with offsets
    holdAndClear();
    dmem[10] = 32'hDEAD_BEEF;
    emit(encI(2, 1, 0, 32'h1234)); // 0
    emit(32'd0);
    emit(32'd0);
    emit(encI(4, 1, 0, 16));       // 3: store to word 4
    emit(encI(3, 2, 0, 16));       // 4: load right after store
    emit(encI(3, 3, 0, 40));       // 5: preset word 10
    emit(32'd0);
    emit(encI(4, 2, 0, 20));       // 7
    emit(encI(4, 3, 0, 24));       // 8
    emit(encI(2, 4, 0, 48));       // 9
    emit(32'd0);
    emit(32'd0);
    emit(encI(3, 5, 4, -8));       // 12: word 10 via negative offset
    emit(32'd0);
    emit(32'd0);
    emit(encI(4, 5, 0, 28));       // 15
    emit(encI(4, 1, 4, -12));      // 16: store to word 9
    emit(encI(5, 0, 0, -4));
    releaseAndRun(50);
    check("R7", "store word 4", dmem[4], 32'h1234);
    check("R6", "load after store", dmem[5], 32'h1234);
    check("R6", "load preset word", dmem[6], 32'hDEAD_BEEF);
    check("R6", "load negative offset", dmem[7], 32'hDEAD_BEEF);
    check("R7", "store negative offset", dmem[9], 32'h1234);

    // R10 taken and not-taken branches
    holdAndClear();
    emit(encI(2, 1, 0, 1));        // 0
    emit(encI(2, 2, 0, 1));        // 1
    emit(32'd0);
    emit(32'd0);
    emit(encI(5, 2, 1, 12));       // 4: r1 == r2, taken to slot 8
    emit(encI(4, 1, 0, 0));        // 5 flushed
    emit(encI(4, 1, 0, 4));        // 6 flushed
    emit(encI(4, 1, 0, 8));        // 7 flushed
    emit(encI(4, 2, 0, 12));       // 8 target
    emit(encI(5, 0, 1, 12));       // 9: r1 != r0, falls through
    emit(encI(4, 1, 0, 16));       // 10
    emit(encI(4, 1, 0, 20));       // 11
    emit(encI(4, 1, 0, 24));       // 12
    emit(encI(5, 0, 0, -4));
    releaseAndRun(50);
    for (int k = 0; k < 3; k++)
      check("R10", $sformatf("flushed store word %0d", k), dmem[k], 32'd0);
    check("R10", "branch target store", dmem[3], 32'd1);
    for (int k = 4; k < 7; k++)
      check("R10", $sformatf("fall-through store word %0d", k), dmem[k], 32'd1);
    check("R10", "store count", 32'(storeCount), 32'd4);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule